// File: doc/BRIEF.md
# Upper-Word Bit-Field Insert Unit

This execution unit handles one 64-bit instruction that writes a right-aligned slice of a source operand into a chosen span of a destination operand. The span always falls inside the upper word (bits 32 to 63). The unit receives the 32-bit instruction word, the two operand values already fetched from the register file, and the architecture revision of the core. One clock later it returns the merged value with a valid strobe.

The instruction holds both span limits as 5-bit values offset down by 32. The unit adds the offset back, builds a contiguous mask from the two limits and merges the operands under that mask. It reports three other outcomes:
- An instruction word that is not its own opcode is marked as foreign, so that a dispatcher can route it elsewhere.
- On a core revision older than 2 the instruction is marked as a reserved instruction.
- A span whose low limit is above its high limit is flagged as undefined, and the destination operand is passed through unchanged.

Top module: `bfins_upper_unit`

## Requirements
- R1: An instruction is claimed only when bits 31..26 equal 6'b010110 and bits 5..0 equal 6'b110100. The register-select bits 25..16 do not affect decoding. Any other word yields `out_not_mine`=1, `out_result`=0, and `out_reserved`=0, `out_undef`=0.
- R2: The high limit is `instr[15:11]`+32 and the low limit is `instr[10:6]`+32, so both lie in 32..63.
- R3: For a claimed instruction on revision 2 or later with low <= high, `out_result` equals the destination bits 63..high+1, then source bits (high-low)..0, then destination bits low-1..0, joined in that order. All three flags are 0.
- R4: The widest span (low 32, high 63) replaces the whole upper word with source bits 31..0 and keeps the lower word, without any shift overflow.
- R5: For a claimed instruction on revision 2 or later with low > high, `out_undef`=1, `out_result` equals the destination operand, and the other flags are 0.
- R6: For a claimed instruction with `isa_rev` < 2, `out_reserved`=1, `out_result`=0 and `out_undef`=0, whatever the span limits.
- R7: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. A synchronous active-high reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are presented this cycle |
| instr | input | 32 | Instruction word |
| op_dst | input | 64 | Destination operand value (the old value of the target register) |
| op_src | input | 64 | Source operand value |
| isa_rev | input | 3 | Architecture revision implemented by the core |
| out_valid | output | 1 | Registered outputs are valid |
| out_result | output | 64 | Merged value |
| out_reserved | output | 1 | Reserved-instruction condition |
| out_undef | output | 1 | Undefined span (low above high) |
| out_not_mine | output | 1 | Opcode not handled by this unit |

## Verification
The corner cases are the spans that touch bit 63 or bit 32, in particular the full 32-bit span, where a shift by the field width can overflow. The inverted-limit encodings, which are a large share of all encodings, are the other hard case. Random operands rarely reach any of these, so the stimulus steps through every one of the 1024 pairs of limit encodings, each with fresh random operands and random register-select bits. Separate passes repeat a sample of encodings on old revisions and with corrupted major or minor opcodes.

// File: rtl/bfins_pkg.sv
package bfins_pkg;
  localparam int XLEN = 64;
  localparam int ILEN = 32;
  localparam int POSW = 6;
  localparam int REVW = 3;
  localparam logic [5:0] OPC_MAJOR = 6'b010110;
  localparam logic [5:0] OPC_MINOR = 6'b110100;
  localparam logic [REVW-1:0] MIN_REV = 3'd2;

  typedef struct packed {
    logic            hit;
    logic [POSW-1:0] hi;
    logic [POSW-1:0] lo;
  } dec_t;

  // contiguous ones from lo to hi inclusive (requires lo <= hi)
  function automatic logic [XLEN-1:0] span_mask(input logic [POSW-1:0] hi,
                                                 input logic [POSW-1:0] lo);
    logic [POSW:0] wdt;
    logic [XLEN:0] ones;
    wdt  = {1'b0, hi} - {1'b0, lo} + (POSW+1)'(1);
    ones = ((XLEN+1)'(1) << wdt) - (XLEN+1)'(1);
    return ones[XLEN-1:0] << lo;
  endfunction

  function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] dst,
                                            input logic [XLEN-1:0] src,
                                            input logic [XLEN-1:0] msk,
                                            input logic [POSW-1:0] lo);
    return (dst & ~msk) | ((src << lo) & msk);
  endfunction
endpackage

// File: rtl/bfins_decode.sv
module bfins_decode
  import bfins_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  input  logic [REVW-1:0] isa_rev,
  output dec_t            dec,
  output logic            rev_ok,
  output logic            inverted
);
  always_comb begin
    dec.hit  = (instr[31:26] == OPC_MAJOR) && (instr[5:0] == OPC_MINOR);
    dec.hi   = {1'b1, instr[15:11]};
    dec.lo   = {1'b1, instr[10:6]};
    rev_ok   = (isa_rev >= MIN_REV);
    inverted = dec.lo > dec.hi;
  end
endmodule

// File: rtl/bfins_mask.sv
module bfins_mask
  import bfins_pkg::*;
(
  input  logic [POSW-1:0] hi,
  input  logic [POSW-1:0] lo,
  output logic [XLEN-1:0] msk
);
  assign msk = span_mask(hi, lo);
endmodule

// File: rtl/bfins_merge.sv
module bfins_merge
  import bfins_pkg::*;
(
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] msk,
  input  logic [POSW-1:0] lo,
  output logic [XLEN-1:0] res
);
  assign res = merge(dst, src, msk, lo);
endmodule

// File: rtl/bfins_upper_unit.sv
module bfins_upper_unit
  import bfins_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] op_dst,
  input  logic [XLEN-1:0] op_src,
  input  logic [REVW-1:0] isa_rev,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_reserved,
  output logic            out_undef,
  output logic            out_not_mine
);
  dec_t            dec;
  logic            rev_ok;
  logic            inverted;
  logic [XLEN-1:0] msk;
  logic [XLEN-1:0] merged;

  // named events for the checker
  logic            foreign_evt;
  logic            reserved_evt;
  logic            undef_evt;
  logic            exec_evt;

  bfins_decode u_dec (
    .instr    (instr),
    .isa_rev  (isa_rev),
    .dec      (dec),
    .rev_ok   (rev_ok),
    .inverted (inverted)
  );

  bfins_mask u_mask (
    .hi  (dec.hi),
    .lo  (dec.lo),
    .msk (msk)
  );

  bfins_merge u_merge (
    .dst (op_dst),
    .src (op_src),
    .msk (msk),
    .lo  (dec.lo),
    .res (merged)
  );

  assign foreign_evt  = !dec.hit;
  assign reserved_evt = dec.hit && !rev_ok;
  assign undef_evt    = dec.hit && rev_ok && inverted;
  assign exec_evt     = dec.hit && rev_ok && !inverted;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_reserved <= 1'b0;
      out_undef    <= 1'b0;
      out_not_mine <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_not_mine <= foreign_evt;
        out_reserved <= reserved_evt;
        out_undef    <= undef_evt;
        if (exec_evt)       out_result <= merged;
        else if (undef_evt) out_result <= op_dst;
        else                out_result <= '0;
      end
    end
  end
endmodule

// File: rtl/bfins_checker.sv
module bfins_checker
  import bfins_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] op_dst,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_reserved,
  input logic            out_undef,
  input logic            out_not_mine,
  input logic            foreign_evt,
  input logic            reserved_evt,
  input logic            undef_evt,
  input logic            exec_evt
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_reserved, out_undef, out_not_mine}) <= 1); // R1
  AST_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && foreign_evt) |=> (out_not_mine && out_result == '0)); // R1
  AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && undef_evt) |=> (out_undef && out_result == $past(op_dst))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && exec_evt) |=> (out_result[31:0] == $past(op_dst[31:0]))); // R3
  AST_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && reserved_evt) |=> (out_reserved && out_result == '0)); // R6
endmodule

bind bfins_upper_unit bfins_checker u_chk (.*);

// File: tb/bfins_upper_unit_test.sv
module bfins_upper_unit_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        rsv;
    logic        und;
    logic        nm;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] op_dst = '0;
  logic [63:0] op_src = '0;
  logic [2:0]  isa_rev = 3'd2;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_reserved, out_undef, out_not_mine;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  bfins_upper_unit uut (.*);

  function automatic logic [63:0] ref_insert(input logic [63:0] d, input logic [63:0] s,
                                             input int hi, input int lo);
    logic [63:0] r;
    for (int i = 0; i < 64; i++)
      r[i] = (i > hi || i < lo) ? d[i] : s[i-lo];
    return r;
  endfunction

  task automatic send(input logic [31:0] iw, input logic [63:0] d, input logic [63:0] s,
                      input logic [2:0] rev, input string req);
    exp_t e;
    int hi, lo;
    hi = 32 + int'(iw[15:11]);
    lo = 32 + int'(iw[10:6]);
    e.nm  = (iw[31:26] != 6'b010110) || (iw[5:0] != 6'b110100);
    e.rsv = !e.nm && (rev < 3'd2);
    e.und = !e.nm && !e.rsv && (lo > hi);
    if (e.nm || e.rsv) e.res = '0;
    else if (e.und)    e.res = d;
    else               e.res = ref_insert(d, s, hi, lo);
    e.req = req;
    @(negedge clk);
    in_valid = 1'b1; instr = iw; op_dst = d; op_src = s; isa_rev = rev;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    instr = $urandom;
  endtask

  function automatic logic [31:0] mk(input logic [4:0] hm, input logic [4:0] lm);
    logic [9:0] sel;
    sel = 10'($urandom);
    return {6'b010110, sel, hm, lm, 6'b110100};
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (out_valid) begin
          checks++;
          if (q.size() == 0) begin
            errors++;
            $display("FAIL R7: out_valid=1 expected 0 (no pending item)");
          end else begin
            exp_t e;
            e = q.pop_front();
            if (out_result !== e.res || out_reserved !== e.rsv ||
                out_undef !== e.und || out_not_mine !== e.nm) begin
              errors++;
              $display("FAIL %s: res=%h rsv=%b und=%b nm=%b expected res=%h rsv=%b und=%b nm=%b",
                       e.req, out_result, out_reserved, out_undef, out_not_mine,
                       e.res, e.rsv, e.und, e.nm);
            end
          end
        end else if (q.size() != 0) begin
          checks++;
          errors++;
          $display("FAIL R7: out_valid=0 expected 1");
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7: reset out_valid=%b expected 0", out_valid);
    end
    rst = 1'b0;
    idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7: idle out_valid=%b expected 0", out_valid);
    end
    // R2 R3 R4 R5: every pair of limit encodings
    for (int h = 0; h < 32; h++)
      for (int l = 0; l < 32; l++) begin
        string tag;
        if (l > h)                  tag = "R5";
        else if (h == 31 && l == 0) tag = "R4";
        else                        tag = "R2 R3";
        send(mk(5'(h), 5'(l)), {$urandom, $urandom}, {$urandom, $urandom}, 3'd2, tag);
      end
    // R4 with later revisions and fixed patterns
    send(mk(5'd31, 5'd0), 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_DEAD_BEEF, 3'd5, "R4");
    send(mk(5'd31, 5'd31), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd7, "R3");
    // R6: old revisions
    for (int k = 0; k < 16; k++)
      send(mk(5'($urandom), 5'($urandom)), {$urandom, $urandom}, {$urandom, $urandom},
           3'(k % 2), "R6");
    idle();
    // R1: foreign opcodes
    for (int k = 0; k < 16; k++) begin
      logic [31:0] iw;
      iw = mk(5'($urandom), 5'($urandom));
      if (k % 2 == 0) iw[31:26] = iw[31:26] ^ 6'(1 + ($urandom % 63));
      else            iw[5:0]   = iw[5:0]   ^ 6'(1 + ($urandom % 63));
      send(iw, {$urandom, $urandom}, {$urandom, $urandom}, 3'(k % 8), "R1");
    end
    idle();
    idle();
    @(negedge clk);
    checks++;
    if (q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7: pending=%0d out_valid=%b expected 0 and 0", q.size(), out_valid);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule